// File: doc/BRIEF.md
# Sampled Channel Current Balancer

This block evens out the current carried by the phases of a multi-phase buck converter. In each switching period it receives one digitised current sample per active phase, taken while that phase's low-side switch conducts. When every active phase has delivered its sample, the block forms the mean of those samples. For each phase it then takes the deviation of that phase's sample from the mean.

Each deviation passes through a shift-based first-order low-pass filter. The filtered value is added to the shared duty command, which gives each phase its own compare value. A phase that carries less than the mean gets a longer pulse, and a phase that carries more gets a shorter one. A mode input selects two or three active phases. In two-phase mode the third phase is excluded entirely. A period tick from the modulator opens each new sampling round.

Top module: `cur_balancer`

## Requirements
- R1: While rst_ni is low and after its release, every compare output is 0 and every filter state is 0.
- R2: A sample is captured on its valid strobe. After a tick_i pulse, the balance update takes place only once every active phase has presented a valid sample. Until then the outputs do not change.
- R3: The mean is the floor of the sum of the active samples divided by the active count. For three phases, the reciprocal multiply is exact over the whole input range, so the error is zero.
- R4: The error of each phase is the mean minus that phase's sample. A positive error raises the compare value of that phase.
- R5: On each update the filter state of an active phase becomes y + floor((e - y) / 2^FILT_K). The default is FILT_K = 2.
- R6: Each compare output is registered. It equals cmd_i + y clamped to the range 0 to CMD_MAX (default 1000), one clock after cmd_i is presented, and it never wraps.
- R7: When two_phase_i is 1, phase index 2 is inactive. Its strobe and sample are ignored, it does not enter the mean, its filter state is held at 0, and its output slice adj_o[3*CMD_W-1:2*CMD_W] is 0.
- R8: At most one update takes place per round. Strobes that arrive after the update and before the next tick_i leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Start of a switching period; clears the captured-sample flags |
| two_phase_i | input | 1 | 1 selects two active phases (0 and 1); 0 selects three |
| smp_i | input | 3*SAMPLE_W | Current samples; phase n in bits [n*SAMPLE_W +: SAMPLE_W] |
| smp_vld_i | input | 3 | Per-phase sample strobe; bit n belongs to phase n |
| cmd_i | input | CMD_W | Shared duty command |
| adj_o | output | 3*CMD_W | Per-phase compare values; phase n in bits [n*CMD_W +: CMD_W] |

## Verification
On every cycle the assertions check four things: the outputs stay within the legal compare range, the inactive phase reads zero in two-phase mode, at most one update takes place per round, and the outputs stay still while neither the command, the mode nor the filter state moves. The numerical behaviour can only be shown by the bench's scenarios, which compare against a reference model. This covers the exact floor of the two- and three-phase means, the sign of the correction, the filter recurrence across successive rounds and clamping at both ends. The same holds for the withholding of the update until the last active sample arrives.

// File: rtl/cb_pkg.sv
package cb_pkg;
  localparam int NUM_CH = 3;
endpackage

// File: rtl/cb_capture.sv
module cb_capture
  import cb_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [NUM_CH-1:0]          act_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_i,
  input  logic [NUM_CH-1:0]          vld_i,
  output logic [NUM_CH*SAMPLE_W-1:0] smp_o,
  output logic                       upd_o
);
  logic [NUM_CH-1:0] got_q;
  logic [NUM_CH-1:0] take;
  logic              done_q;

  assign take  = vld_i & act_i;
  // fire once per round, when every active lane has reported
  assign upd_o = (&(got_q | ~act_i)) & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q  <= '0;
      done_q <= 1'b0;
    end else begin
      got_q  <= tick_i ? take : (got_q | take);
      done_q <= tick_i ? 1'b0 : (done_q | upd_o);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) smp_o[c*SAMPLE_W +: SAMPLE_W] <= '0;
      else if (take[c] && !(done_q && !tick_i))
        smp_o[c*SAMPLE_W +: SAMPLE_W] <= smp_i[c*SAMPLE_W +: SAMPLE_W];
    end
  end
endmodule

// File: rtl/cb_mean.sv
module cb_mean
  import cb_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_i,
  input  logic                       three_i,
  output logic [SAMPLE_W-1:0]        mean_o
);
  localparam int SUM_W  = SAMPLE_W + 2;
  // shift one past the sum width keeps ceil-reciprocal division exact
  localparam int DIV_SH = SUM_W + 1;
  localparam int PROD_W = SUM_W + DIV_SH;
  localparam logic [DIV_SH-1:0] RECIP = DIV_SH'(((1 << DIV_SH) + 2) / 3);

  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] prod;

  always_comb begin
    sum = {2'b00, smp_i[0 +: SAMPLE_W]} + {2'b00, smp_i[SAMPLE_W +: SAMPLE_W]};
    if (three_i) sum = sum + {2'b00, smp_i[2*SAMPLE_W +: SAMPLE_W]};
    prod = PROD_W'(sum) * PROD_W'(RECIP);
    if (three_i) mean_o = prod[DIV_SH +: SAMPLE_W];
    else         mean_o = sum[1 +: SAMPLE_W];
  end
endmodule

// File: rtl/cb_filter.sv
module cb_filter #(
  parameter int SAMPLE_W = 10,
  parameter int FILT_K   = 2,
  localparam int E_W     = SAMPLE_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upd_i,
  input  logic                  act_i,
  input  logic [SAMPLE_W-1:0]   mean_i,
  input  logic [SAMPLE_W-1:0]   smp_i,
  output logic signed [E_W-1:0] y_o
);
  logic signed [E_W-1:0] err;
  logic signed [E_W:0]   diff;
  logic signed [E_W:0]   step;

  assign err  = $signed({1'b0, mean_i}) - $signed({1'b0, smp_i});
  assign diff = $signed({err[E_W-1], err}) - $signed({y_o[E_W-1], y_o});
  assign step = diff >>> FILT_K;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_o <= '0;
    else if (!act_i) y_o <= '0;
    else if (upd_i)  y_o <= y_o + step[E_W-1:0];
  end
endmodule

// File: rtl/cb_sat.sv
module cb_sat #(
  parameter int CMD_W   = 10,
  parameter int E_W     = 11,
  parameter int CMD_MAX = 1000
) (
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic signed [E_W-1:0] y_i,
  input  logic                  act_i,
  output logic [CMD_W-1:0]      adj_o
);
  localparam int S_W = ((CMD_W > E_W) ? CMD_W : E_W) + 2;
  localparam logic [S_W-1:0] LIM = S_W'(CMD_MAX);

  logic [S_W-1:0] tot;

  assign tot = {{(S_W-CMD_W){1'b0}}, cmd_i} + {{(S_W-E_W){y_i[E_W-1]}}, y_i};

  always_comb begin
    if (!act_i)           adj_o = '0;
    else if (tot[S_W-1])  adj_o = '0;
    else if (tot > LIM)   adj_o = LIM[CMD_W-1:0];
    else                  adj_o = tot[CMD_W-1:0];
  end
endmodule

// File: rtl/cur_balancer.sv
module cur_balancer
  import cb_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CMD_W    = 10,
  parameter int CMD_MAX  = 1000,
  parameter int FILT_K   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       two_phase_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_i,
  input  logic [NUM_CH-1:0]          smp_vld_i,
  input  logic [CMD_W-1:0]           cmd_i,
  output logic [NUM_CH*CMD_W-1:0]    adj_o
);
  localparam int E_W = SAMPLE_W + 1;

  logic [NUM_CH-1:0]          act;
  logic [NUM_CH*SAMPLE_W-1:0] smp_q;
  logic                       upd_w;
  logic [SAMPLE_W-1:0]        mean_w;

  assign act = {~two_phase_i, 2'b11};

  cb_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .act_i (act),
    .smp_i (smp_i),
    .vld_i (smp_vld_i),
    .smp_o (smp_q),
    .upd_o (upd_w)
  );

  cb_mean #(.SAMPLE_W(SAMPLE_W)) u_mean (
    .smp_i  (smp_q),
    .three_i(~two_phase_i),
    .mean_o (mean_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic signed [E_W-1:0] y_w;
    logic [CMD_W-1:0]      adj_w;

    cb_filter #(.SAMPLE_W(SAMPLE_W), .FILT_K(FILT_K)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .upd_i (upd_w),
      .act_i (act[c]),
      .mean_i(mean_w),
      .smp_i (smp_q[c*SAMPLE_W +: SAMPLE_W]),
      .y_o   (y_w)
    );

    cb_sat #(.CMD_W(CMD_W), .E_W(E_W), .CMD_MAX(CMD_MAX)) u_sat (
      .cmd_i(cmd_i),
      .y_i  (y_w),
      .act_i(act[c]),
      .adj_o(adj_w)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) adj_o[c*CMD_W +: CMD_W] <= '0;
      else         adj_o[c*CMD_W +: CMD_W] <= adj_w;
    end
  end
endmodule

// File: rtl/cb_chk.sv
module cb_chk #(
  parameter int CMD_W   = 10,
  parameter int CMD_MAX = 1000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               two_phase_i,
  input logic [CMD_W-1:0]   cmd_i,
  input logic [3*CMD_W-1:0] adj_o,
  input logic               upd_i
);
  // R6
  adj_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_o[0 +: CMD_W] <= CMD_W'(CMD_MAX)) && (adj_o[CMD_W +: CMD_W] <= CMD_W'(CMD_MAX))
    && (adj_o[2*CMD_W +: CMD_W] <= CMD_W'(CMD_MAX)));

  // R7
  idle_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    two_phase_i |=> (adj_o[2*CMD_W +: CMD_W] == '0));

  // R8
  single_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !tick_i) |=> !upd_i);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(upd_i) && $stable(cmd_i) && $stable(two_phase_i)) |=> $stable(adj_o));
endmodule

bind cur_balancer cb_chk #(.CMD_W(CMD_W), .CMD_MAX(CMD_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .two_phase_i(two_phase_i),
  .cmd_i      (cmd_i),
  .adj_o      (adj_o),
  .upd_i      (upd_w)
);

// File: tb/cur_balancer_tb.sv
module cur_balancer_tb;
  localparam int SW = 10;
  localparam int CW = 10;
  localparam int CMAX = 1000;
  localparam int K = 2;
  localparam int NV = 8;
  // tp, s0, s1, s2, cmd
  localparam int VEC [NV][5] = '{
    '{0, 300, 300, 300, 500},
    '{0, 400, 200, 300, 500},
    '{0, 100, 101, 103, 400},
    '{1, 600, 200, 999, 512},
    '{1, 201, 200, 0, 300},
    '{0, 1000, 0, 0, 50},
    '{0, 1000, 0, 0, 990},
    '{0, 1023, 1023, 1022, 700}
  };

  logic clk = 0, rst_n = 0, tick = 0, tp = 0;
  logic [3*SW-1:0] smp = '0;
  logic [2:0] vld = '0;
  logic [CW-1:0] cmd = '0;
  logic [3*CW-1:0] adj;

  int n_chk = 0, n_bad = 0;
  int ym [3] = '{0, 0, 0};
  int pend [3] = '{0, 0, 0};
  int cur_tp = 0, cur_cmd = 0;

  always #5 clk = ~clk;

  cur_balancer #(.SAMPLE_W(SW), .CMD_W(CW), .CMD_MAX(CMAX), .FILT_K(K)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .two_phase_i(tp),
    .smp_i(smp), .smp_vld_i(vld), .cmd_i(cmd), .adj_o(adj));

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v < 0) ? 0 : ((v > CMAX) ? CMAX : v);
  endfunction

  function automatic int exp_adj(input int c);
    return (cur_tp == 1 && c == 2) ? 0 : sat(cur_cmd + ym[c]);
  endfunction

  task automatic chk_all(input string req);
    for (int c = 0; c < 3; c++) chk(req, int'(adj[c*CW +: CW]), exp_adj(c));
  endtask

  task automatic model_update();
    int mean, e;
    mean = (cur_tp == 1) ? (pend[0] + pend[1]) / 2 : (pend[0] + pend[1] + pend[2]) / 3;
    for (int c = 0; c < 3; c++) begin
      if (cur_tp == 1 && c == 2) ym[c] = 0;
      else begin
        e = mean - pend[c];
        ym[c] = ym[c] + ((e - ym[c]) >>> K);
      end
    end
  endtask

  task automatic send(input int c, input int v);
    @(negedge clk);
    smp[c*SW +: SW] = SW'(v);
    vld = 3'b000; vld[c] = 1'b1;
    @(negedge clk);
    vld = 3'b000;
  endtask

  task automatic start_round(input int t, input int cm);
    @(negedge clk);
    tp = t[0]; cmd = CW'(cm); tick = 1'b1;
    cur_tp = t; cur_cmd = cm;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_all("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 after release");

    // R3 R4 R5 R6 R7 via table
    for (int i = 0; i < NV; i++) begin
      start_round(VEC[i][0], VEC[i][4]);
      for (int c = 0; c < 3; c++) begin
        send(c, VEC[i][c + 1]);
        if (!(cur_tp == 1 && c == 2)) pend[c] = VEC[i][c + 1];
      end
      repeat (3) @(negedge clk);
      model_update();
      chk_all($sformatf("R3 R4 R5 R6 R7 vector %0d", i));
    end

    // R2: no update until last active sample
    start_round(0, 600);
    send(0, 800); pend[0] = 800;
    send(1, 100); pend[1] = 100;
    repeat (3) @(negedge clk);
    chk_all("R2 partial round held");
    send(2, 450); pend[2] = 450;
    repeat (3) @(negedge clk);
    model_update();
    chk_all("R2 update after last sample");

    // R8: late strobes in the same round ignored
    send(0, 5); send(1, 1000); send(2, 0);
    repeat (3) @(negedge clk);
    chk_all("R8 extra strobes ignored");

    // R6: one-cycle command latency and clamping at both ends
    @(negedge clk); cmd = CW'(0); cur_cmd = 0;
    @(negedge clk);
    chk_all("R6 low clamp");
    cmd = CW'(1023); cur_cmd = 1023;
    @(negedge clk);
    chk_all("R6 high clamp");
    cmd = CW'(333); cur_cmd = 333;
    @(negedge clk);
    chk_all("R6 latency");

    // R7: third lane strobe in two-phase mode leaves mean alone
    start_round(1, 400);
    send(0, 300); pend[0] = 300;
    send(2, 1023);
    send(1, 310); pend[1] = 310;
    repeat (3) @(negedge clk);
    model_update();
    chk_all("R7 idle lane excluded");

    // R1: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 3; c++) ym[c] = 0;
    cur_cmd = 0; cmd = '0;
    chk_all("R1 reset mid-run");
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule